// File: doc/BRIEF.md
# Parallel Pin Controller with Set/Clear Attribute Registers

This block controls a bank of general-purpose pins from a simple memory-mapped register bus. Each pin has eight one-bit attributes, each held in its own state vector. Software changes an attribute only through two write-only words, one that sets the bits written as 1 and one that clears them. A third word reads the state back. Bits written as 0 are left alone, so several agents can change different pins without a read-modify-write race.

The pad side combines the attributes. A pin is owned either by the controller or by one of two peripheral functions, and the owner supplies its output value and output enable. An open-drain option lets an enabled pin drive only low. The pull-up attribute goes to the pad as its own output. On the input side, the pads pass through a two-flop synchronizer and an optional glitch filter. A change detector collects level changes into a change-status word that clears itself when read. The masked change status raises a level interrupt.

Top module: `pio_ctrl`

## Requirements
- R1: After reset all attributes are zero except pull-up and controller ownership, which are all ones. The change status is zero, `irq_o` is low and no pad is driven.
- R2: Attribute k (0 output enable, 1 open-drain, 2 pull-up, 3 glitch filter, 4 controller ownership, 5 interrupt mask, 6 output data, 7 peripheral select with 1 = B) has its set word at byte offset 0x10*k. A write there ORs the data into the state of that attribute only. Zero bits and other attributes are unchanged.
- R3: A write to offset 0x10*k+0x4 clears the state bits written as 1. Zero bits and other attributes are unchanged.
- R4: A read of offset 0x10*k+0x8 returns the state of attribute k. Reads of the set and clear words, of 0x10*k+0xC and of any unmapped or unaligned address return zero.
- R5: A read of offset 0x80 returns the synchronized level of every pin, whatever its direction. A new pin level is readable from the third clock edge after it is applied.
- R6: With the filter off, a pin pulse that lasts one clock is recorded as a change. With the filter on, the same pulse is ignored, and a pulse that lasts two clocks is accepted.
- R7: Every change of a pin's filtered level sets its bit in the change status at offset 0x84. A read returns the status and clears it. A change that lands in the same cycle as the read stays set after the clear.
- R8: `irq_o` is high exactly when some change-status bit has its interrupt-mask bit set.
- R9: On a controller-owned pin without open-drain, the pad value equals the output data and the pad enable equals the output enable.
- R10: On a pin owned by a peripheral, the pad value and enable come from peripheral B when its select bit is 1, and from peripheral A otherwise.
- R11: With open-drain set, the pad value is 0 and the pad is enabled only when the selected source is enabled and its value is 0.
- R12: `pad_pu_o` equals the pull-up state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Byte address |
| bus_wdata_i | input | NPINS | Write data |
| bus_rdata_o | output | NPINS | Read data, valid in the access cycle |
| pin_i | input | NPINS | Pad input levels |
| pa_out_i | input | NPINS | Peripheral A output value |
| pa_oe_i | input | NPINS | Peripheral A output enable |
| pb_out_i | input | NPINS | Peripheral B output value |
| pb_oe_i | input | NPINS | Peripheral B output enable |
| pad_out_o | output | NPINS | Pad output value |
| pad_oe_o | output | NPINS | Pad output enable |
| pad_pu_o | output | NPINS | Pad pull-up enable |
| irq_o | output | 1 | Masked change interrupt |

## Verification
A read of the change status and a fresh pin change can fall in the same cycle. The bench provokes this by toggling one pin a fixed number of edges before a status read, so that the filtered change reaches the status register on the read's own clock edge. The read must return only the older bit, and the next read must return the new bit, so the clear must not swallow the new change.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int NUM_ATTR = 8;
  typedef enum logic [2:0] {
    A_OE, A_ODRN, A_PULL, A_FILT, A_OWN, A_IMSK, A_DOUT, A_PSEL
  } attr_e;
  // attributes whose reset state is all ones: pull-up, ownership
  localparam logic [NUM_ATTR-1:0] RST_ONES = 8'b0001_0100;
  localparam logic [1:0] SLOT_SET  = 2'd0;
  localparam logic [1:0] SLOT_CLR  = 2'd1;
  localparam logic [1:0] SLOT_STAT = 2'd2;
  localparam int LVL_OFS = 'h80;
  localparam int CHG_OFS = 'h84;
endpackage

// File: rtl/pio_set_clr_reg.sv
module pio_set_clr_reg #(
  parameter int W       = 32,
  parameter bit RST_ONE = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= {W{RST_ONE}};
    else if (set_i)  q_o <= q_o | mask_i;
    else if (clr_i)  q_o <= q_o & ~mask_i;
  end
endmodule

// File: rtl/pio_in_filter.sv
module pio_in_filter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] flt_en_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] s1_q, s2_q, s2_d_q, filt_q, prev_q;
  logic [W-1:0] stable;

  assign stable = ~(s2_q ^ s2_d_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      s2_d_q <= '0;
      filt_q <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      s2_d_q <= s2_q;
      // filtered pins take a new level only after two equal samples
      filt_q <= (s2_q & (~flt_en_i | stable)) | (filt_q & flt_en_i & ~stable);
      prev_q <= filt_q;
    end
  end

  assign lvl_o = s2_q;
  assign chg_o = filt_q ^ prev_q;
endmodule

// File: rtl/pio_pad_mux.sv
module pio_pad_mux #(
  parameter int W = 32
) (
  input  logic [W-1:0] own_i,
  input  logic [W-1:0] psel_i,
  input  logic [W-1:0] dout_i,
  input  logic [W-1:0] oe_i,
  input  logic [W-1:0] odrn_i,
  input  logic [W-1:0] pa_out_i,
  input  logic [W-1:0] pa_oe_i,
  input  logic [W-1:0] pb_out_i,
  input  logic [W-1:0] pb_oe_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o
);
  logic [W-1:0] per_out, per_oe, src_out, src_oe;

  always_comb begin
    per_out   = (psel_i & pb_out_i) | (~psel_i & pa_out_i);
    per_oe    = (psel_i & pb_oe_i)  | (~psel_i & pa_oe_i);
    src_out   = (own_i & dout_i) | (~own_i & per_out);
    src_oe    = (own_i & oe_i)   | (~own_i & per_oe);
    pad_out_o = src_out & ~odrn_i;
    pad_oe_o  = src_oe & (~odrn_i | ~src_out);
  end
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [NPINS-1:0] bus_wdata_i,
  output logic [NPINS-1:0] bus_rdata_o,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] pa_out_i,
  input  logic [NPINS-1:0] pa_oe_i,
  input  logic [NPINS-1:0] pb_out_i,
  input  logic [NPINS-1:0] pb_oe_i,
  output logic [NPINS-1:0] pad_out_o,
  output logic [NPINS-1:0] pad_oe_o,
  output logic [NPINS-1:0] pad_pu_o,
  output logic             irq_o
);
  logic [NUM_ATTR-1:0][NPINS-1:0] attr_q;
  logic [NPINS-1:0] lvl, chg, isr_q;
  logic       acc_ok, in_attr, wr, rd, rd_chg;
  logic [2:0] idx;
  logic [1:0] slot;

  assign acc_ok  = bus_sel_i && (bus_addr_i[1:0] == 2'b00);
  assign in_attr = (bus_addr_i[AW-1:7] == '0);
  assign idx     = bus_addr_i[6:4];
  assign slot    = bus_addr_i[3:2];
  assign wr      = acc_ok && bus_we_i && in_attr;
  assign rd      = acc_ok && !bus_we_i;
  assign rd_chg  = rd && (bus_addr_i == AW'(CHG_OFS));

  for (genvar k = 0; k < NUM_ATTR; k++) begin : g_attr
    pio_set_clr_reg #(.W(NPINS), .RST_ONE(RST_ONES[k])) i_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (wr && (idx == 3'(k)) && (slot == SLOT_SET)),
      .clr_i  (wr && (idx == 3'(k)) && (slot == SLOT_CLR)),
      .mask_i (bus_wdata_i),
      .q_o    (attr_q[k])
    );
  end

  pio_in_filter #(.W(NPINS)) i_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (pin_i),
    .flt_en_i (attr_q[A_FILT]),
    .lvl_o    (lvl),
    .chg_o    (chg)
  );

  // clear on read, but a change landing on the same edge survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (rd_chg ? '0 : isr_q) | chg;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      if (in_attr && slot == SLOT_STAT)            bus_rdata_o = attr_q[idx];
      else if (bus_addr_i == AW'(LVL_OFS))         bus_rdata_o = lvl;
      else if (bus_addr_i == AW'(CHG_OFS))         bus_rdata_o = isr_q;
    end
  end

  pio_pad_mux #(.W(NPINS)) i_mux (
    .own_i     (attr_q[A_OWN]),
    .psel_i    (attr_q[A_PSEL]),
    .dout_i    (attr_q[A_DOUT]),
    .oe_i      (attr_q[A_OE]),
    .odrn_i    (attr_q[A_ODRN]),
    .pa_out_i  (pa_out_i),
    .pa_oe_i   (pa_oe_i),
    .pb_out_i  (pb_out_i),
    .pb_oe_i   (pb_oe_i),
    .pad_out_o (pad_out_o),
    .pad_oe_o  (pad_oe_o)
  );

  assign pad_pu_o = attr_q[A_PULL];
  assign irq_o    = |(isr_q & attr_q[A_IMSK]);
endmodule

// File: rtl/pio_ctrl_chk.sv
module pio_ctrl_chk
  import pio_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           bus_sel_i,
  input logic                           bus_we_i,
  input logic [AW-1:0]                  bus_addr_i,
  input logic [NPINS-1:0]               bus_wdata_i,
  input logic [NPINS-1:0]               bus_rdata_o,
  input logic [NUM_ATTR-1:0][NPINS-1:0] attr_q,
  input logic [NPINS-1:0]               isr_q,
  input logic [NPINS-1:0]               chg,
  input logic [NPINS-1:0]               pad_out_o,
  input logic                           irq_o
);
  logic       ok, top0, rd_chg, wr_set, wr_clr, rd_wo;
  logic [2:0] ax;

  assign ok     = bus_sel_i && bus_addr_i[1:0] == 2'b00;
  assign top0   = bus_addr_i[AW-1:7] == '0;
  assign ax     = bus_addr_i[6:4];
  assign wr_set = ok && bus_we_i && top0 && bus_addr_i[3:2] == 2'd0;
  assign wr_clr = ok && bus_we_i && top0 && bus_addr_i[3:2] == 2'd1;
  assign rd_wo  = ok && !bus_we_i && top0 && bus_addr_i[3:2] != 2'd2;
  assign rd_chg = ok && !bus_we_i && bus_addr_i == AW'(CHG_OFS);

  p_set_or_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> attr_q[$past(ax)] == ($past(attr_q[ax]) | $past(bus_wdata_i)));

  p_clr_and_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> attr_q[$past(ax)] == ($past(attr_q[ax]) & ~$past(bus_wdata_i)));

  p_wo_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_wo |-> bus_rdata_o == '0);

  p_read_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_chg |=> isr_q == $past(chg));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_chg |=> isr_q == ($past(isr_q) | $past(chg)));

  p_mask_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attr_q[A_IMSK] == '0 |-> !irq_o);

  p_own_data_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o ^ attr_q[A_DOUT]) & attr_q[A_OWN] & ~attr_q[A_ODRN]) == '0);

  p_odrn_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & attr_q[A_ODRN]) == '0);
endmodule

bind pio_ctrl pio_ctrl_chk #(.NPINS(NPINS), .AW(AW)) i_pio_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .attr_q      (attr_q),
  .isr_q       (isr_q),
  .chg         (chg),
  .pad_out_o   (pad_out_o),
  .irq_o       (irq_o)
);

// File: tb/test_pio_ctrl.sv
module test_pio_ctrl;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0, we = 1'b0;
  logic [7:0]    addr = '0;
  logic [N-1:0]  wdata = '0, rdata;
  logic [N-1:0]  pin = '0, pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;
  logic [N-1:0]  pad_out, pad_oe, pad_pu;
  logic          irq;

  int n_run = 0, n_fail = 0;
  logic [N-1:0] m [8];
  logic [31:0]  seed = 32'h1234_5678;
  logic         done = 1'b0;

  always #4 clk = ~clk;

  pio_ctrl #(.NPINS(N), .AW(8)) i_pio_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_i(pin), .pa_out_i(pa_out), .pa_oe_i(pa_oe), .pb_out_i(pb_out),
    .pb_oe_i(pb_oe), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .pad_pu_o(pad_pu), .irq_o(irq)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed ^ (seed >> 13);
  endfunction

  task automatic bus_wr(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [N-1:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1;
    sel = 1'b0;
  endtask

  task automatic put(input int k, input logic [N-1:0] v);
    bus_wr(8'(k * 16 + 4), '1);
    bus_wr(8'(k * 16), v);
    m[k] = v;
  endtask

  task automatic check_pads(input string req);
    logic [N-1:0] po, pe, so, se;
    po = (m[7] & pb_out) | (~m[7] & pa_out);
    pe = (m[7] & pb_oe)  | (~m[7] & pa_oe);
    so = (m[4] & m[6]) | (~m[4] & po);
    se = (m[4] & m[0]) | (~m[4] & pe);
    #1;
    check({req, " pad_out"}, pad_out, so & ~m[1]);
    check({req, " pad_oe"},  pad_oe,  se & ~(m[1] & so));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] r;
    for (int k = 0; k < 8; k++) m[k] = (k == 2 || k == 4) ? '1 : '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int k = 0; k < 8; k++) begin
      bus_rd(8'(k * 16 + 8), r);
      check($sformatf("R1 reset attr %0d", k), r, m[k]);
    end
    bus_rd(8'h84, r); check("R1 reset change status", r, '0);
    check("R1 reset irq", {31'b0, irq}, '0);
    check("R1 reset pad_oe", pad_oe, '0);

    // R2/R3 set/clear isolation sweep, all attributes checked after each op
    for (int k = 0; k < 8; k++) begin
      for (int j = 0; j < 6; j++) begin
        logic [N-1:0] p;
        p = nxt();
        if (j % 2 == 0) begin bus_wr(8'(k * 16), p);     m[k] = m[k] | p;  end
        else            begin bus_wr(8'(k * 16 + 4), p); m[k] = m[k] & ~p; end
        for (int q = 0; q < 8; q++) begin
          bus_rd(8'(q * 16 + 8), r);
          check($sformatf("%s op attr %0d read attr %0d", (j % 2 == 0) ? "R2" : "R3", k, q), r, m[q]);
        end
      end
    end
    // write of zeros has no effect
    bus_wr(8'h60, '0); bus_wr(8'h64, '0);
    bus_rd(8'h68, r); check("R2 R3 zero write", r, m[6]);

    // R4 write-only and unmapped reads
    for (int k = 0; k < 8; k++) begin
      bus_rd(8'(k * 16), r);     check("R4 set word reads zero", r, '0);
      bus_rd(8'(k * 16 + 4), r); check("R4 clear word reads zero", r, '0);
      bus_rd(8'(k * 16 + 12), r); check("R4 spare word reads zero", r, '0);
    end
    bus_rd(8'h88, r); check("R4 unmapped", r, '0);
    bus_rd(8'h6A, r); check("R4 unaligned", r, '0);

    // R12 pull-up
    for (int j = 0; j < 4; j++) begin
      put(2, nxt()); #1 check("R12 pull-up", pad_pu, m[2]);
    end

    // R9 controller-owned, no open-drain
    put(1, '0); put(4, '1);
    for (int j = 0; j < 6; j++) begin
      put(0, nxt()); put(6, nxt()); check_pads("R9");
    end
    // R10 peripheral ownership
    for (int j = 0; j < 8; j++) begin
      pa_out = nxt(); pa_oe = nxt(); pb_out = nxt(); pb_oe = nxt();
      put(4, nxt()); put(7, nxt()); check_pads("R10");
    end
    // R11 open-drain across both owners
    for (int j = 0; j < 8; j++) begin
      pa_out = nxt(); pa_oe = nxt(); pb_out = nxt(); pb_oe = nxt();
      put(1, nxt()); put(0, nxt()); put(6, nxt()); put(4, nxt());
      check_pads("R11");
    end

    // R5 pin level readback
    put(5, '0); put(3, '0); put(0, '1); put(4, '1);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk) pin = nxt();
      repeat (3) @(posedge clk);
      bus_rd(8'h80, r); check("R5 pin level", r, pin);
    end
    @(negedge clk) pin = '0;
    repeat (6) @(posedge clk);
    bus_rd(8'h84, r);
    bus_rd(8'h84, r); check("R7 status cleared after read", r, '0);

    // R6 glitch filter
    @(negedge clk) pin[0] = 1'b1;
    @(negedge clk) pin[0] = 1'b0;
    repeat (6) @(posedge clk);
    bus_rd(8'h84, r); check("R6 unfiltered one-clock pulse", r, 32'h1);
    put(3, 32'h2);
    @(negedge clk) pin[1] = 1'b1;
    @(negedge clk) pin[1] = 1'b0;
    repeat (6) @(posedge clk);
    bus_rd(8'h84, r); check("R6 filtered one-clock pulse ignored", r, '0);
    @(negedge clk) pin[1] = 1'b1;
    @(negedge clk);
    @(negedge clk) pin[1] = 1'b0;
    repeat (6) @(posedge clk);
    bus_rd(8'h84, r); check("R6 filtered two-clock pulse", r, 32'h2);

    // R7 change arriving on the read edge
    @(negedge clk) pin[2] = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk) pin[3] = 1'b1;
    repeat (3) @(posedge clk);
    bus_rd(8'h84, r); check("R7 read returns older change", r, 32'h4);
    bus_rd(8'h84, r); check("R7 same-cycle change kept", r, 32'h8);
    bus_rd(8'h84, r); check("R7 cleared", r, '0);

    // R8 interrupt masking
    put(5, 32'h10);
    @(negedge clk) pin[5] = 1'b1;
    repeat (6) @(posedge clk);
    #1 check("R8 unmasked change no irq", {31'b0, irq}, '0);
    @(negedge clk) pin[4] = 1'b1;
    repeat (6) @(posedge clk);
    #1 check("R8 masked change raises irq", {31'b0, irq}, 32'h1);
    bus_rd(8'h84, r); check("R8 status", r, 32'h30);
    check("R8 irq drops after read", {31'b0, irq}, '0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule